// File: doc/BRIEF.md
# Multicycle Processor Step Sequencer

This block is the control unit of a processor whose instructions run through a single shared datapath. One instruction takes several clock cycles, and the cycles are called steps. The first step fetches the instruction. The second step decodes it and precomputes a branch target. The remaining one to three steps execute the instruction, access memory or write back a result, depending on the instruction class. The sequencer is a Moore machine with ten steps. Each step drives one fixed pattern on the datapath control pins, whatever the opcode, so the control pins never change in the middle of a cycle.

The 6-bit opcode comes from the instruction register. The sequencer reads it only when it picks the next step, which happens in the decode step and in the address step. The sequencer supports loads, stores, register-to-register operations, branch-if-equal and jumps. An opcode it does not recognise goes straight back to fetch and writes nothing. Both the opcode and the control pins are plain level signals with no handshake: the datapath acts on the control pins in every cycle.

Top module: `mcfsm_ctrl`

## Requirements

Control bits not named for a step below are 0 in that step. The two-bit fields are encoded as follows:
- `alu_b_sel`: 00 = register B, 01 = constant four, 10 = sign-extended immediate, 11 = immediate shifted left by two.
- `alu_mode`: 00 = add, 01 = subtract, 10 = operation taken from the function field.
- `pc_next_sel`: 00 = ALU result, 01 = registered ALU output, 10 = jump target.

The requirements:
- R1: A cycle with `rst` high forces the fetch step on the next clock edge. This holds from any step.
- R2: The fetch step asserts `pc_wr_en`, `mem_rd` and `ir_load`, with `alu_b_sel`=01. Every instruction starts in this step and then moves to decode.
- R3: The decode step asserts only `alu_b_sel`=11. It selects the next step from `opcode`: 100011 (load) and 101011 (store) go to the address step, 000000 (register type) goes to execute, 000100 (branch-equal) goes to branch, and 000010 (jump) goes to jump.
- R4: A load takes 5 cycles in this order:
  - fetch;
  - decode;
  - address (`alu_a_reg`, `alu_b_sel`=10);
  - memory read (`mem_rd`, `addr_data`);
  - write-back (`rf_wr`, `wb_sel_mem`).
- R5: A store takes 4 cycles: fetch, decode, address, then memory write (`mem_wr`, `addr_data`).
- R6: A register-type instruction takes 4 cycles in this order:
  - fetch;
  - decode;
  - execute (`alu_a_reg`, `alu_b_sel`=00, `alu_mode`=10);
  - write-back (`rf_wr`, `rf_dst_rd`).
- R7: A branch-equal takes 3 cycles. Its last step asserts `pc_wr_if_eq` and `alu_a_reg`, with `alu_mode`=01 and `pc_next_sel`=01.
- R8: A jump takes 3 cycles. Its last step asserts `pc_wr_en` with `pc_next_sel`=10.
- R9: Any other opcode in the decode step returns to fetch after 2 cycles. No write enable is asserted during those 2 cycles.
- R10: The control pins depend only on the current step. A change of `opcode` within a cycle never changes them.
- R11: At most one of `ir_load`, `mem_wr`, `rf_wr` and `pc_wr_if_eq` is asserted in any cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr_en | output | 1 | Unconditional program counter write |
| pc_wr_if_eq | output | 1 | Program counter write when the ALU reports equal |
| addr_data | output | 1 | Memory address taken from the ALU output register (0 = program counter) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_sel_mem | output | 1 | Register write data taken from the memory data register |
| ir_load | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Write destination is the rd field (0 = rt field) |
| alu_a_reg | output | 1 | ALU operand A is register A (0 = program counter) |
| alu_b_sel | output | 2 | ALU operand B select |
| alu_mode | output | 2 | ALU operation class |
| pc_next_sel | output | 2 | Program counter source select |

## Verification

A wrong step register shows up at the control pins in the same cycle it is taken, because every step has its own output pattern. Most wrong transitions are visible within one cycle as a pattern that does not belong at that point in the instruction. A missing or extra step is visible as a cycle-count error when the next fetch pattern arrives early or late. Sweeping all 64 opcodes separates the five decoded classes from the unrecognised ones. Perturbing the opcode inside non-branching steps exposes any path from the opcode into the outputs.

// File: rtl/mcfsm_pkg.sv
package mcfsm_pkg;
  localparam int OPC_W  = 6;
  localparam int STEP_W = 4;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MRD    = 4'd3,
    ST_MWB    = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXE    = 4'd6,
    ST_RWB    = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JMP    = 4'd9
  } step_e;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef struct packed {
    logic       pc_wr_en;
    logic       pc_wr_if_eq;
    logic       addr_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_sel_mem;
    logic       ir_load;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       alu_a_reg;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_next_sel;
  } ctrl_t;
endpackage

// File: rtl/mcfsm_next.sv
module mcfsm_next
  import mcfsm_pkg::*;
(
  input  step_e             cur,
  input  logic [OPC_W-1:0]  opcode,
  output step_e             nxt
);
  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nxt = ST_ADDR;
        else if (opcode == OPC_RTYPE)                  nxt = ST_EXE;
        else if (opcode == OPC_BEQ)                    nxt = ST_BEQ;
        else if (opcode == OPC_JUMP)                   nxt = ST_JMP;
        else                                           nxt = ST_FETCH;
      end
      ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_MWR : ST_MRD;
      ST_MRD:    nxt = ST_MWB;
      ST_EXE:    nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcfsm_decode.sv
module mcfsm_decode
  import mcfsm_pkg::*;
(
  input  step_e cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.pc_wr_en  = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      ST_MRD: begin
        ctl.mem_rd    = 1'b1;
        ctl.addr_data = 1'b1;
      end
      ST_MWB: begin
        ctl.rf_wr      = 1'b1;
        ctl.wb_sel_mem = 1'b1;
      end
      ST_MWR: begin
        ctl.mem_wr    = 1'b1;
        ctl.addr_data = 1'b1;
      end
      ST_EXE: begin
        ctl.alu_a_reg = 1'b1;
        ctl.alu_mode  = 2'b10;
      end
      ST_RWB: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      ST_BEQ: begin
        ctl.pc_wr_if_eq = 1'b1;
        ctl.alu_a_reg   = 1'b1;
        ctl.alu_mode    = 2'b01;
        ctl.pc_next_sel = 2'b01;
      end
      ST_JMP: begin
        ctl.pc_wr_en    = 1'b1;
        ctl.pc_next_sel = 2'b10;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcfsm_ctrl.sv
module mcfsm_ctrl
  import mcfsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       pc_wr_en,
  output logic       pc_wr_if_eq,
  output logic       addr_data,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       wb_sel_mem,
  output logic       ir_load,
  output logic       rf_wr,
  output logic       rf_dst_rd,
  output logic       alu_a_reg,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_mode,
  output logic [1:0] pc_next_sel
);
  step_e st_q, st_d;
  ctrl_t ctl;

  mcfsm_next u_next (.cur(st_q), .opcode(opcode), .nxt(st_d));
  mcfsm_decode u_dec (.cur(st_q), .ctl(ctl));

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FETCH;
    else     st_q <= st_d;
  end

  assign pc_wr_en    = ctl.pc_wr_en;
  assign pc_wr_if_eq = ctl.pc_wr_if_eq;
  assign addr_data   = ctl.addr_data;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign wb_sel_mem  = ctl.wb_sel_mem;
  assign ir_load     = ctl.ir_load;
  assign rf_wr       = ctl.rf_wr;
  assign rf_dst_rd   = ctl.rf_dst_rd;
  assign alu_a_reg   = ctl.alu_a_reg;
  assign alu_b_sel   = ctl.alu_b_sel;
  assign alu_mode    = ctl.alu_mode;
  assign pc_next_sel = ctl.pc_next_sel;
endmodule

// File: rtl/mcfsm_ctrl_chk.sv
module mcfsm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pc_wr_en,
  input logic       pc_wr_if_eq,
  input logic       addr_data,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_sel_mem,
  input logic       ir_load,
  input logic       rf_wr,
  input logic [1:0] alu_b_sel,
  input logic [1:0] pc_next_sel
);
  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (ir_load && mem_rd && pc_wr_en));

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (alu_b_sel == 2'b11 && !rf_wr && !mem_wr && !ir_load));

  p_read_then_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_data) |=> (rf_wr && wb_sel_mem));

  p_store_ends_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_load);

  p_branch_ends_r7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_if_eq |=> ir_load);

  p_jump_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_en && pc_next_sel == 2'b10) |=> ir_load);

  p_single_write_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({ir_load, mem_wr, rf_wr, pc_wr_if_eq}) <= 1);
endmodule

bind mcfsm_ctrl mcfsm_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .pc_wr_en(pc_wr_en), .pc_wr_if_eq(pc_wr_if_eq),
  .addr_data(addr_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .wb_sel_mem(wb_sel_mem), .ir_load(ir_load), .rf_wr(rf_wr),
  .alu_b_sel(alu_b_sel), .pc_next_sel(pc_next_sel)
);

// File: tb/mcfsm_ctrl_tb_top.sv
module mcfsm_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pc_wr_en, pc_wr_if_eq, addr_data, mem_rd, mem_wr, wb_sel_mem;
  logic       ir_load, rf_wr, rf_dst_rd, alu_a_reg;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mcfsm_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr_en(pc_wr_en), .pc_wr_if_eq(pc_wr_if_eq), .addr_data(addr_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_sel_mem(wb_sel_mem),
    .ir_load(ir_load), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
    .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_mode(alu_mode),
    .pc_next_sel(pc_next_sel)
  );

  // Vector layout: [15] pc_wr_en [14] pc_wr_if_eq [13] addr_data [12] mem_rd
  // [11] mem_wr [10] wb_sel_mem [9] ir_load [8] rf_wr [7] rf_dst_rd
  // [6] alu_a_reg [5:4] alu_b_sel [3:2] alu_mode [1:0] pc_next_sel
  function automatic logic [15:0] pat(input int st);
    case (st)
      0: return 16'h9210;  // fetch: pc write, read, ir load, B=four
      1: return 16'h0030;  // decode: B=shifted immediate
      2: return 16'h0060;  // address: A=reg, B=immediate
      3: return 16'h3000;  // memory read at data address
      4: return 16'h0500;  // load write-back from memory register
      5: return 16'h2800;  // memory write at data address
      6: return 16'h0048;  // execute: A=reg, mode=function
      7: return 16'h0180;  // register write to rd
      8: return 16'h4045;  // branch: cond write, subtract, src=01
      default: return 16'h8002;  // jump: pc write, src=10
    endcase
  endfunction

  function automatic logic [15:0] act();
    return {pc_wr_en, pc_wr_if_eq, addr_data, mem_rd, mem_wr, wb_sel_mem,
            ir_load, rf_wr, rf_dst_rd, alu_a_reg, alu_b_sel, alu_mode, pc_next_sel};
  endfunction

  task automatic chk(input string req, input logic [15:0] exp);
    n_chk++;
    if (act() !== exp) begin
      n_err++;
      $display("FAIL %s: controls=%h expected=%h (opcode=%b)", req, act(), exp, opcode);
    end
  endtask

  // Runs one instruction starting at a negedge inside the fetch step and
  // ends at the negedge of the next fetch step.
  task automatic run_instr(input logic [5:0] op);
    int seq[5];
    int len;
    string req;
    case (op)
      6'b100011: begin seq = '{0,1,2,3,4}; len = 5; req = "R4"; end
      6'b101011: begin seq = '{0,1,2,5,0}; len = 4; req = "R5"; end
      6'b000000: begin seq = '{0,1,6,7,0}; len = 4; req = "R6"; end
      6'b000100: begin seq = '{0,1,8,0,0}; len = 3; req = "R7"; end
      6'b000010: begin seq = '{0,1,9,0,0}; len = 3; req = "R8"; end
      default:   begin seq = '{0,1,0,0,0}; len = 2; req = "R9"; end
    endcase
    chk("R2 fetch", pat(0));
    opcode = op;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      chk(i == 1 ? "R3 decode" : req, pat(seq[i]));
      if (seq[i] != 1 && seq[i] != 2) begin
        // R10: perturb opcode inside a cycle, outputs must not move
        opcode = op ^ 6'h3f;
        #1;
        chk("R10 opcode-independent", pat(seq[i]));
        opcode = op;
      end
      if (seq[i] == 1 || len == 2)
        if (rf_wr || mem_wr || pc_wr_if_eq) begin
          n_chk++; n_err++;
          $display("FAIL R9: write enable active act=%h expected no writes", act());
        end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung act=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", pat(0));

    // R3..R9: exhaustive opcode sweep
    for (int op = 0; op < 64; op++) run_instr(6'(op));
    // back-to-back classes in mixed order
    run_instr(6'b000010);
    run_instr(6'b100011);
    run_instr(6'b000100);
    run_instr(6'b101011);
    run_instr(6'b000000);

    // R1: reset in the middle of a load
    chk("R2 fetch", pat(0));
    opcode = 6'b100011;
    @(negedge clk);
    @(negedge clk);
    chk("R4 address", pat(2));
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-load", pat(0));
    rst = 1'b0;
    run_instr(6'b000000);
    chk("R2 fetch after recovery", pat(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule